// File: doc/BRIEF.md
# SuperSpeed Link Power State Controller

This block manages the link power state of a single SuperSpeed port. It holds the link in one of four states: U0 (active), U1 (light sleep with a fast wake), U2 (deeper sleep with a slower wake) and U3 (suspend). While the link has no traffic it counts idle clock edges. When an enabled threshold is reached it moves the link into U1, and later into U2, and it pulses a request strobe that says which state it chose.

The link partner can also ask for U1 or U2. The controller accepts or rejects each such request in one cycle. The decision depends on pending traffic, the enable bits and whether the link is settled in U0.

Leaving a low-power state is timed. In U1 or U2, pending traffic or a partner exit event starts an exit counter. In U3 only a resume event starts it. The counter length grows with the depth of the state, and U0 is reported only when the counter runs out. U3 is entered only on an explicit suspend command.

Top module: `lpm_link_ctrl`

## Requirements
- R1: After reset the link reports U0, `exit_busy` is low and every strobe is low. `link_state` encodes U0=0, U1=1, U2=2, U3=3.
- R2: In U0 with `u1_en` high, after IDLE_U1_CYC consecutive clock edges with `traffic_pend` low, the link reports U1. In that same cycle `entry_req` is high for exactly one cycle with `entry_req_u2`=0.
- R3: A clock edge with `traffic_pend` high restarts the idle count, so entry needs a fresh run of IDLE_U1_CYC idle edges.
- R4: In U1 with `u2_en` high, IDLE_U2_CYC further idle edges move the link to U2, with a one-cycle `entry_req` and `entry_req_u2`=1. In U0 with `u1_en` low and `u2_en` high, U2 is entered directly after IDLE_U2_CYC idle edges.
- R5: A `partner_req` sampled in settled U0 (no exit running), with `traffic_pend` low and the target enabled, is accepted. `partner_tgt_u2`=0 targets U1 and 1 targets U2. `link_acc` pulses for one cycle and the link reports the target from the next edge.
- R6: A `partner_req` sampled while `traffic_pend` is high, or while the target state is disabled, gives a one-cycle `link_rej`. The state does not change.
- R7: A `partner_req` sampled outside settled U0 is rejected. If it arrives together with `suspend_cmd`, it is rejected and the suspend is taken. `link_acc` and `link_rej` are never high together.
- R8: In U1 or U2, `traffic_pend` or `partner_exit` raises `exit_busy` at the next edge. The link reports U0, with `exit_busy` low, exactly EXIT_U1_CYC or EXIT_U2_CYC edges after that. The state holds while the exit runs.
- R9: A `suspend_cmd` in settled U0 moves the link to U3 at the next edge. In U3 pending traffic has no effect. Only `resume_evt` starts an exit, and U0 follows EXIT_U3_CYC edges after `exit_busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u1_en | input | 1 | Allows entry to U1 |
| u2_en | input | 1 | Allows entry to U2 |
| traffic_pend | input | 1 | Traffic is waiting for the link |
| partner_req | input | 1 | Link partner asks for low-power entry |
| partner_tgt_u2 | input | 1 | Target of the partner request: 0 = U1, 1 = U2 |
| partner_exit | input | 1 | Link partner starts an exit from U1/U2 |
| suspend_cmd | input | 1 | Command to enter U3 |
| resume_evt | input | 1 | Resume event that leaves U3 |
| link_state | output | 2 | Current state: 0 = U0, 1 = U1, 2 = U2, 3 = U3 |
| exit_busy | output | 1 | Exit toward U0 in progress |
| entry_req | output | 1 | One-cycle strobe for a locally initiated entry |
| entry_req_u2 | output | 1 | Target of the local entry: 0 = U1, 1 = U2 |
| link_acc | output | 1 | One-cycle accept of a partner request |
| link_rej | output | 1 | One-cycle reject of a partner request |

## Verification
The bench checks the exact edge on which idle entry fires, including an idle run that traffic breaks one edge short of the threshold. A counter that does not restart would enter U1 early, and an off-by-one comparison would move the event by a cycle.

Each exit latency is measured from the rise of `exit_busy` to the U0 report, for U1, U2 and U3. A design that shared one latency across states, or reported U0 before the counter ran out, would put those events on the wrong cycle.

Partner requests are sent under pending traffic, with a disabled target, while in U3, and together with a suspend. A design that accepted any of these would show `link_acc` and a state change where only `link_rej` is expected. Holding traffic high for a long stretch in U3 also exposes a design that wakes without a resume.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LS_U0 = 2'd0,
    LS_U1 = 2'd1,
    LS_U2 = 2'd2,
    LS_U3 = 2'd3
  } lstate_t;
endpackage

// File: rtl/lpm_idle_timer.sv
// Counts consecutive idle edges while the link is active or in U1.
module lpm_idle_timer #(
  parameter int U1_THR = 64,
  parameter int U2_THR = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic traffic_pend,
  output logic hit_u1,
  output logic hit_u2
);
  localparam int TOP = (U1_THR > U2_THR) ? U1_THR : U2_THR;
  localparam int CW  = $clog2(TOP + 1);
  localparam logic [CW-1:0] TOP_V = CW'(TOP);
  localparam logic [CW-1:0] U1_V  = CW'(U1_THR - 1);
  localparam logic [CW-1:0] U2_V  = CW'(U2_THR - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          idle;

  assign idle   = run && !traffic_pend;
  assign hit_u1 = idle && (cnt_q >= U1_V);
  assign hit_u2 = idle && (cnt_q >= U2_V);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr || !idle) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != TOP_V) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpm_exit_timer.sv
// Times the wake from a low-power state; the length depends on the state.
module lpm_exit_timer
  import lpm_pkg::*;
#(
  parameter int L_U1 = 8,
  parameter int L_U2 = 64,
  parameter int L_U3 = 4096
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  lstate_t start_st,
  output logic    busy,
  output logic    done
);
  localparam int LMAX = (L_U3 > L_U2) ? ((L_U3 > L_U1) ? L_U3 : L_U1)
                                      : ((L_U2 > L_U1) ? L_U2 : L_U1);
  localparam int CW = $clog2(LMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, load_v;
  logic          busy_q, busy_d;
  logic          upd_en;

  always_comb begin
    unique case (start_st)
      LS_U1:   load_v = CW'(L_U1 - 1);
      LS_U2:   load_v = CW'(L_U2 - 1);
      default: load_v = CW'(L_U3 - 1);
    endcase
  end

  assign done = busy_q && (cnt_q == '0);
  assign busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    upd_en = start || busy_q;
    if (start && !busy_q) begin
      cnt_d  = load_v;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/lpm_partner_judge.sv
// Accept/reject decision for a low-power entry asked for by the link partner.
module lpm_partner_judge
  import lpm_pkg::*;
(
  input  lstate_t st,
  input  logic    busy,
  input  logic    req,
  input  logic    tgt_u2,
  input  logic    u1_en,
  input  logic    u2_en,
  input  logic    traffic_pend,
  input  logic    suspend,
  output logic    accept,
  output logic    reject
);
  logic settled, tgt_ok, grant;

  assign settled = (st == LS_U0) && !busy;
  assign tgt_ok  = tgt_u2 ? u2_en : u1_en;
  assign grant   = settled && !suspend && !traffic_pend && tgt_ok;
  assign accept  = req && grant;
  assign reject  = req && !grant;
endmodule

// File: rtl/lpm_link_ctrl.sv
module lpm_link_ctrl
  import lpm_pkg::*;
#(
  parameter int IDLE_U1_CYC = 64,
  parameter int IDLE_U2_CYC = 256,
  parameter int EXIT_U1_CYC = 8,
  parameter int EXIT_U2_CYC = 64,
  parameter int EXIT_U3_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       u1_en,
  input  logic       u2_en,
  input  logic       traffic_pend,
  input  logic       partner_req,
  input  logic       partner_tgt_u2,
  input  logic       partner_exit,
  input  logic       suspend_cmd,
  input  logic       resume_evt,
  output logic [1:0] link_state,
  output logic       exit_busy,
  output logic       entry_req,
  output logic       entry_req_u2,
  output logic       link_acc,
  output logic       link_rej
);
  lstate_t st_q, st_d;
  logic    st_en;
  logic    req_q, req_d, req_u2_q, req_u2_d;
  logic    acc_q, rej_q, acc_w, rej_w;
  logic    hit_u1, hit_u2, idle_run;
  logic    exit_start, exit_done, busy_w;

  assign idle_run = !busy_w && ((st_q == LS_U0) || (st_q == LS_U1));

  lpm_idle_timer #(
    .U1_THR(IDLE_U1_CYC),
    .U2_THR(IDLE_U2_CYC)
  ) i_idle (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (idle_run),
    .clr          (st_en),
    .traffic_pend (traffic_pend),
    .hit_u1       (hit_u1),
    .hit_u2       (hit_u2)
  );

  lpm_exit_timer #(
    .L_U1(EXIT_U1_CYC),
    .L_U2(EXIT_U2_CYC),
    .L_U3(EXIT_U3_CYC)
  ) i_exit (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (exit_start),
    .start_st (st_q),
    .busy     (busy_w),
    .done     (exit_done)
  );

  lpm_partner_judge i_judge (
    .st           (st_q),
    .busy         (busy_w),
    .req          (partner_req),
    .tgt_u2       (partner_tgt_u2),
    .u1_en        (u1_en),
    .u2_en        (u2_en),
    .traffic_pend (traffic_pend),
    .suspend      (suspend_cmd),
    .accept       (acc_w),
    .reject       (rej_w)
  );

  // Next-state logic: priority in U0 is suspend, then partner, then local idle.
  always_comb begin
    st_d       = st_q;
    req_d      = 1'b0;
    req_u2_d   = 1'b0;
    exit_start = 1'b0;
    if (exit_done) begin
      st_d = LS_U0;
    end else if (!busy_w) begin
      unique case (st_q)
        LS_U0: begin
          if (suspend_cmd) begin
            st_d = LS_U3;
          end else if (acc_w) begin
            st_d = partner_tgt_u2 ? LS_U2 : LS_U1;
          end else if (u1_en && hit_u1) begin
            st_d  = LS_U1;
            req_d = 1'b1;
          end else if (!u1_en && u2_en && hit_u2) begin
            st_d     = LS_U2;
            req_d    = 1'b1;
            req_u2_d = 1'b1;
          end
        end
        LS_U1: begin
          if (traffic_pend || partner_exit) begin
            exit_start = 1'b1;
          end else if (u2_en && hit_u2) begin
            st_d     = LS_U2;
            req_d    = 1'b1;
            req_u2_d = 1'b1;
          end
        end
        LS_U2: exit_start = traffic_pend || partner_exit;
        default: exit_start = resume_evt;
      endcase
    end
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= LS_U0;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      req_u2_q <= 1'b0;
      acc_q    <= 1'b0;
      rej_q    <= 1'b0;
    end else begin
      req_q    <= req_d;
      req_u2_q <= req_u2_d;
      acc_q    <= acc_w;
      rej_q    <= rej_w;
    end
  end

  assign link_state   = st_q;
  assign exit_busy    = busy_w;
  assign entry_req    = req_q;
  assign entry_req_u2 = req_u2_q;
  assign link_acc     = acc_q;
  assign link_rej     = rej_q;
endmodule

// File: rtl/lpm_link_ctrl_chk.sv
module lpm_link_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       traffic_pend,
  input logic       partner_req,
  input logic       suspend_cmd,
  input logic       resume_evt,
  input logic [1:0] link_state,
  input logic       exit_busy,
  input logic       entry_req,
  input logic       entry_req_u2,
  input logic       link_acc,
  input logic       link_rej
);
  // R7
  acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_acc && link_rej));

  // R5
  acc_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_acc |-> ($past(partner_req) && !$past(traffic_pend)));

  // R2
  req_matches_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |-> (link_state == (entry_req_u2 ? 2'd2 : 2'd1)));

  // R8
  exit_lands_u0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exit_busy) |-> (link_state == 2'd0));

  // R8
  exit_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_busy && $past(exit_busy)) |-> $stable(link_state));

  // R9
  u3_by_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 2'd3 && $past(link_state) != 2'd3) |-> $past(suspend_cmd));

  // R9
  u3_wake_by_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(exit_busy) && link_state == 2'd3) |-> $past(resume_evt));
endmodule

bind lpm_link_ctrl lpm_link_ctrl_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .traffic_pend (traffic_pend),
  .partner_req  (partner_req),
  .suspend_cmd  (suspend_cmd),
  .resume_evt   (resume_evt),
  .link_state   (link_state),
  .exit_busy    (exit_busy),
  .entry_req    (entry_req),
  .entry_req_u2 (entry_req_u2),
  .link_acc     (link_acc),
  .link_rej     (link_rej)
);

// File: tb/test_lpm_link_ctrl.sv
`timescale 1ns/1ps
module test_lpm_link_ctrl;
  localparam int TI1 = 6;
  localparam int TI2 = 10;
  localparam int TX1 = 3;
  localparam int TX2 = 7;
  localparam int TX3 = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, u1_en, u2_en, traffic_pend, partner_req, partner_tgt_u2;
  logic       partner_exit, suspend_cmd, resume_evt;
  logic [1:0] link_state;
  logic       exit_busy, entry_req, entry_req_u2, link_acc, link_rej;

  lpm_link_ctrl #(
    .IDLE_U1_CYC(TI1), .IDLE_U2_CYC(TI2),
    .EXIT_U1_CYC(TX1), .EXIT_U2_CYC(TX2), .EXIT_U3_CYC(TX3)
  ) i_lpm_link_ctrl (
    .clk(clk), .rst_n(rst_n), .u1_en(u1_en), .u2_en(u2_en),
    .traffic_pend(traffic_pend), .partner_req(partner_req),
    .partner_tgt_u2(partner_tgt_u2), .partner_exit(partner_exit),
    .suspend_cmd(suspend_cmd), .resume_evt(resume_evt),
    .link_state(link_state), .exit_busy(exit_busy), .entry_req(entry_req),
    .entry_req_u2(entry_req_u2), .link_acc(link_acc), .link_rej(link_rej)
  );

  typedef struct {
    int         at;
    logic [6:0] snap;
    string      tag;
  } exp_t;

  exp_t       q[$];
  exp_t       e;
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  int         c;
  bit         mon_on = 1'b0;
  bit         done = 1'b0;
  logic [6:0] last, cur;

  always @(posedge clk) cyc <= cyc + 1;

  // snapshot: {state[1:0], busy, req, req_u2, acc, rej}
  task automatic push(input int at, input logic [1:0] s, input logic b, input logic r,
                      input logic t, input logic a, input logic j, input string tag);
    exp_t x;
    x.at = at; x.snap = {s, b, r, t, a, j}; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: every change seen at the outputs is popped and compared.
  always @(negedge clk) begin
    if (mon_on) begin
      cur = {link_state, exit_busy, entry_req, entry_req_u2, link_acc, link_rej};
      if (cur !== last) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL unexpected event at cycle %0d: actual %b expected none", cyc, cur);
        end else begin
          e = q.pop_front();
          if (e.at != cyc || e.snap !== cur) begin
            fails++;
            $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d",
                     e.tag, cur, cyc, e.snap, e.at);
          end
        end
        last = cur;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; u1_en = 1'b0; u2_en = 1'b0; traffic_pend = 1'b1;
    partner_req = 1'b0; partner_tgt_u2 = 1'b0; partner_exit = 1'b0;
    suspend_cmd = 1'b0; resume_evt = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    checks++;
    cur = {link_state, exit_busy, entry_req, entry_req_u2, link_acc, link_rej};
    if (cur !== 7'b0) begin
      fails++;
      $display("FAIL R1 reset: actual %b expected %b", cur, 7'b0);
    end
    last = 7'b0;
    mon_on = 1'b1;

    // R2 local U1 entry; R8 exit from U1
    u1_en = 1'b1; u2_en = 1'b0; traffic_pend = 1'b0; c = cyc;
    push(c + TI1,     2'd1, 0, 1, 0, 0, 0, "R2 enter U1");
    push(c + TI1 + 1, 2'd1, 0, 0, 0, 0, 0, "R2 strobe end");
    tick(TI1 + 3);
    traffic_pend = 1'b1; c = cyc;
    push(c + 1,       2'd1, 1, 0, 0, 0, 0, "R8 exit U1 start");
    push(c + 1 + TX1, 2'd0, 0, 0, 0, 0, 0, "R8 exit U1 done");
    tick(TX1 + 3);

    // R3 idle restart; R4 U1 to U2
    u2_en = 1'b1; traffic_pend = 1'b0;
    tick(TI1 - 1);
    traffic_pend = 1'b1;
    tick(1);
    traffic_pend = 1'b0; c = cyc + TI1;
    push(c,           2'd1, 0, 1, 0, 0, 0, "R3 enter U1 after restart");
    push(c + 1,       2'd1, 0, 0, 0, 0, 0, "R3 strobe end");
    push(c + TI2,     2'd2, 0, 1, 1, 0, 0, "R4 enter U2 from U1");
    push(c + TI2 + 1, 2'd2, 0, 0, 0, 0, 0, "R4 strobe end");
    tick(c + TI2 + 3 - cyc);
    partner_exit = 1'b1; traffic_pend = 1'b1; c = cyc;
    push(c + 1,       2'd2, 1, 0, 0, 0, 0, "R8 exit U2 start");
    push(c + 1 + TX2, 2'd0, 0, 0, 0, 0, 0, "R8 exit U2 done");
    tick(1);
    partner_exit = 1'b0;
    tick(TX2 + 2);

    // R5 partner accept to U1
    u2_en = 1'b0; traffic_pend = 1'b0; partner_req = 1'b1; partner_tgt_u2 = 1'b0; c = cyc;
    push(c + 1, 2'd1, 0, 0, 0, 1, 0, "R5 accept U1");
    push(c + 2, 2'd1, 0, 0, 0, 0, 0, "R5 accept end");
    tick(1);
    partner_req = 1'b0;
    tick(4);
    traffic_pend = 1'b1; c = cyc;
    push(c + 1,       2'd1, 1, 0, 0, 0, 0, "R8 exit U1 start");
    push(c + 1 + TX1, 2'd0, 0, 0, 0, 0, 0, "R8 exit U1 done");
    tick(TX1 + 3);

    // R6 reject on pending traffic
    partner_req = 1'b1; partner_tgt_u2 = 1'b0; c = cyc;
    push(c + 1, 2'd0, 0, 0, 0, 0, 1, "R6 reject pending");
    push(c + 2, 2'd0, 0, 0, 0, 0, 0, "R6 reject end");
    tick(1);
    partner_req = 1'b0;
    tick(3);

    // R6 reject on disabled target, then R5 accept to U2
    u1_en = 1'b0; u2_en = 1'b0; traffic_pend = 1'b0;
    partner_req = 1'b1; partner_tgt_u2 = 1'b1; c = cyc;
    push(c + 1, 2'd0, 0, 0, 0, 0, 1, "R6 reject disabled");
    push(c + 2, 2'd0, 0, 0, 0, 0, 0, "R6 reject end");
    tick(1);
    partner_req = 1'b0;
    tick(2);
    u2_en = 1'b1; partner_req = 1'b1; c = cyc;
    push(c + 1, 2'd2, 0, 0, 0, 1, 0, "R5 accept U2");
    push(c + 2, 2'd2, 0, 0, 0, 0, 0, "R5 accept end");
    tick(1);
    partner_req = 1'b0;
    tick(3);
    traffic_pend = 1'b1; c = cyc;
    push(c + 1,       2'd2, 1, 0, 0, 0, 0, "R8 exit U2 start");
    push(c + 1 + TX2, 2'd0, 0, 0, 0, 0, 0, "R8 exit U2 done");
    tick(TX2 + 3);

    // R9 suspend, traffic ignored in U3, R7 reject in U3, resume
    suspend_cmd = 1'b1; c = cyc;
    push(c + 1, 2'd3, 0, 0, 0, 0, 0, "R9 enter U3");
    tick(1);
    suspend_cmd = 1'b0;
    tick(25);
    checks++;
    if (link_state !== 2'd3 || exit_busy !== 1'b0) begin
      fails++;
      $display("FAIL R9 traffic in U3: actual state %0d busy %b expected state 3 busy 0",
               link_state, exit_busy);
    end
    traffic_pend = 1'b0; partner_req = 1'b1; partner_tgt_u2 = 1'b1; c = cyc;
    push(c + 1, 2'd3, 0, 0, 0, 0, 1, "R7 reject in U3");
    push(c + 2, 2'd3, 0, 0, 0, 0, 0, "R7 reject end");
    tick(1);
    partner_req = 1'b0;
    tick(2);
    resume_evt = 1'b1; traffic_pend = 1'b1; c = cyc;
    push(c + 1,       2'd3, 1, 0, 0, 0, 0, "R9 resume start");
    push(c + 1 + TX3, 2'd0, 0, 0, 0, 0, 0, "R9 resume done");
    tick(1);
    resume_evt = 1'b0;
    tick(TX3 + 4);

    // R7 suspend together with partner request
    u1_en = 1'b1; traffic_pend = 1'b0; suspend_cmd = 1'b1;
    partner_req = 1'b1; partner_tgt_u2 = 1'b0; c = cyc;
    push(c + 1, 2'd3, 0, 0, 0, 0, 1, "R7 suspend wins");
    push(c + 2, 2'd3, 0, 0, 0, 0, 0, "R7 reject end");
    tick(1);
    suspend_cmd = 1'b0; partner_req = 1'b0;
    tick(3);
    resume_evt = 1'b1; traffic_pend = 1'b1; c = cyc;
    push(c + 1,       2'd3, 1, 0, 0, 0, 0, "R9 resume start");
    push(c + 1 + TX3, 2'd0, 0, 0, 0, 0, 0, "R9 resume done");
    tick(1);
    resume_evt = 1'b0;
    tick(TX3 + 4);

    // R4 direct U0 to U2 with U1 disabled
    u1_en = 1'b0; u2_en = 1'b1; traffic_pend = 1'b0; c = cyc;
    push(c + TI2,     2'd2, 0, 1, 1, 0, 0, "R4 direct U2");
    push(c + TI2 + 1, 2'd2, 0, 0, 0, 0, 0, "R4 strobe end");
    tick(TI2 + 3);
    traffic_pend = 1'b1; c = cyc;
    push(c + 1,       2'd2, 1, 0, 0, 0, 0, "R8 exit U2 start");
    push(c + 1 + TX2, 2'd0, 0, 0, 0, 0, 0, "R8 exit U2 done");
    tick(TX2 + 4);

    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: actual missing event expected %b at cycle %0d",
               q[0].tag, q[0].snap, q[0].at);
    end
    done = 1'b1;
    summary();
  end
endmodule